// File: doc/BRIEF.md
# Converter Event Flag Controller

This block keeps the sticky event flags for the control logic of an analog-to-digital converter. The converter core sends it one-cycle pulses when a conversion finishes, when a whole channel sequence finishes, when sampling ends, when the converter becomes ready, when calibration completes, when a window watchdog trips and when a channel configuration has taken effect. Each pulse latches a flag. The flag stays set until software acknowledges it by writing a one to its bit through a register-style port. Writing a zero to a bit leaves that flag as it is.

Two flags depend on more than one input. The conversion-done flag is also cleared when the data register is read, which a strobe input reports. A conversion that completes while the previous result is still unread raises the overrun flag. The block also runs the channel-reconfiguration handshake. It accepts a configuration write only when no earlier update is still in flight and the configuration-acknowledge flag is clear. It accepts a start command only when no update is in flight. Two gating outputs tell the sequencer what it may accept.

Top module: `adc_flag_ctrl`

## Requirements
- R1: After reset every flag reads 0, `cfg_wr_ok` is 1 and `start_ok` is 1.
- R2: A one-cycle event pulse sets its flag, and `flags_o` shows the flag in the cycle after the pulse. The bit positions are: ready 0, sampling end 1, conversion done 2, sequence done 3, overrun 4, calibration done 5, configuration acknowledge 6, and watchdog k at 7+k.
- R3: A write with `reg_wr_en` high clears every flag whose bit in `reg_wdata` is 1, from the next cycle on. Flags whose bit is 0 keep their value.
- R4: When a set event and a write-one clear hit the same flag in the same cycle, the flag is set afterwards.
- R5: A pulse on `dr_rd` with no conversion event in that cycle clears the conversion-done flag.
- R6: A conversion event while the conversion-done flag is set and `dr_rd` is low sets the overrun flag. The conversion-done flag stays set, even if it was write-one-cleared in that same cycle.
- R7: A conversion event in the same cycle as `dr_rd`, while the conversion-done flag is set, leaves the conversion-done flag set and does not raise overrun.
- R8: A conversion event while the conversion-done flag is clear does not raise overrun.
- R9: The watchdog flags are independent. A hit on one watchdog sets only that watchdog's bit.
- R10: `cfg_wr_req` while `cfg_wr_ok` is 1 starts a pending update. From the next cycle on, `cfg_wr_ok` and `start_ok` are 0, and further configuration requests have no effect.
- R11: The configuration-applied event ends the pending update and sets the acknowledge flag. `start_ok` then returns to 1. `cfg_wr_ok` stays 0 until software clears the acknowledge flag, and configuration requests made in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_ready | input | 1 | Converter ready pulse |
| ev_smp_end | input | 1 | End-of-sampling pulse |
| ev_conv_done | input | 1 | One channel result available |
| ev_seq_done | input | 1 | Channel sequence finished |
| ev_cal_done | input | 1 | Calibration finished |
| ev_cfg_applied | input | 1 | Channel configuration took effect |
| ev_wdg | input | NUM_WDG | Per-watchdog threshold-crossing pulses |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wdata | input | NUM_WDG+7 | Write data, 1 clears that flag |
| dr_rd | input | 1 | Data register read strobe |
| cfg_wr_req | input | 1 | Channel configuration write attempt |
| flags_o | output | NUM_WDG+7 | Current flag values |
| cfg_wr_ok | output | 1 | A configuration write would be accepted |
| start_ok | output | 1 | A start command would be accepted |

## Verification
The bench walks every flag through every combination of prior state, set pulse and write-one or write-zero. A design that let the clear win would lose events, and one that decoded the write mask wrongly would disturb neighbouring bits. It also steps through all sixteen combinations of conversion-done state, conversion event, data read and write-one clear. A wrong overrun rule would either flag an overrun when the old result was read in the same cycle or miss an unread result. The configuration handshake is driven through a pending update, repeated requests, the apply event and the acknowledge clear. A design that reopened configuration writes before the acknowledge was cleared, or kept start blocked after the apply, would show the wrong gating value.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
    // Flag bit positions in the status word
    localparam int unsigned FB_RDY  = 0;
    localparam int unsigned FB_SMP  = 1;
    localparam int unsigned FB_EOC  = 2;
    localparam int unsigned FB_EOS  = 3;
    localparam int unsigned FB_OVR  = 4;
    localparam int unsigned FB_CAL  = 5;
    localparam int unsigned FB_CFG  = 6;
    localparam int unsigned FB_WDG0 = 7;

    typedef struct packed {
        logic flag;
    } cell_st_t;

    typedef struct packed {
        logic pending;
    } gate_st_t;
endpackage

// File: rtl/adc_flag_cell.sv
module adc_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    import adc_flag_pkg::*;

    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R3
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/adc_flag_conv_mon.sv
module adc_flag_conv_mon (
    input  logic ev_conv,
    input  logic dr_rd,
    input  logic w1c_eoc,
    input  logic w1c_ovr,
    input  logic eoc_q,
    output logic eoc_set,
    output logic eoc_clr,
    output logic ovr_set,
    output logic ovr_clr
);
    always_comb begin
        eoc_set = ev_conv;
        eoc_clr = w1c_eoc | dr_rd;
        // an unread result being replaced is an overrun
        ovr_set = ev_conv & eoc_q & ~dr_rd;
        ovr_clr = w1c_ovr;
    end
endmodule

// File: rtl/adc_flag_cfg_gate.sv
module adc_flag_cfg_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr_req,
    input  logic ev_applied,
    input  logic ack_flag,
    output logic cfg_wr_ok,
    output logic start_ok
);
    import adc_flag_pkg::*;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pending) begin
            if (ev_applied) st_d.pending = 1'b0;
        end else if (cfg_wr_req && !ack_flag) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_wr_ok = !st_q.pending && !ack_flag;
    assign start_ok  = !st_q.pending;

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ok && !ev_applied) |=> (!start_ok && !cfg_wr_ok));
    // R10
    take_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_req && cfg_wr_ok) |=> !start_ok);
    // R11
    apply_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ok && ev_applied) |=> start_ok);
endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl #(
    parameter int unsigned NUM_WDG = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_ready,
    input  logic                 ev_smp_end,
    input  logic                 ev_conv_done,
    input  logic                 ev_seq_done,
    input  logic                 ev_cal_done,
    input  logic                 ev_cfg_applied,
    input  logic [NUM_WDG-1:0]   ev_wdg,
    input  logic                 reg_wr_en,
    input  logic [NUM_WDG+6:0]   reg_wdata,
    input  logic                 dr_rd,
    input  logic                 cfg_wr_req,
    output logic [NUM_WDG+6:0]   flags_o,
    output logic                 cfg_wr_ok,
    output logic                 start_ok
);
    import adc_flag_pkg::*;

    localparam int unsigned NFLAGS = FB_WDG0 + NUM_WDG;

    logic [NFLAGS-1:0] set_v, clr_v, w1c_v;
    logic eoc_set, eoc_clr, ovr_set, ovr_clr;

    assign w1c_v = {NFLAGS{reg_wr_en}} & reg_wdata;

    adc_flag_conv_mon u_conv (
        .ev_conv (ev_conv_done),
        .dr_rd   (dr_rd),
        .w1c_eoc (w1c_v[FB_EOC]),
        .w1c_ovr (w1c_v[FB_OVR]),
        .eoc_q   (flags_o[FB_EOC]),
        .eoc_set (eoc_set),
        .eoc_clr (eoc_clr),
        .ovr_set (ovr_set),
        .ovr_clr (ovr_clr)
    );

    always_comb begin
        set_v = '0;
        clr_v = w1c_v;
        set_v[FB_RDY] = ev_ready;
        set_v[FB_SMP] = ev_smp_end;
        set_v[FB_EOC] = eoc_set;
        set_v[FB_EOS] = ev_seq_done;
        set_v[FB_OVR] = ovr_set;
        set_v[FB_CAL] = ev_cal_done;
        set_v[FB_CFG] = ev_cfg_applied;
        for (int k = 0; k < NUM_WDG; k++) set_v[FB_WDG0+k] = ev_wdg[k];
        clr_v[FB_EOC] = eoc_clr;
        clr_v[FB_OVR] = ovr_clr;
    end

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        adc_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[i]),
            .clr_i  (clr_v[i]),
            .flag_o (flags_o[i])
        );
    end

    adc_flag_cfg_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_req (cfg_wr_req),
        .ev_applied (ev_cfg_applied),
        .ack_flag   (flags_o[FB_CFG]),
        .cfg_wr_ok  (cfg_wr_ok),
        .start_ok   (start_ok)
    );

    // R6
    ovr_on_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_conv_done && flags_o[FB_EOC] && !dr_rd) |=> (flags_o[FB_OVR] && flags_o[FB_EOC]));
    // R7
    no_ovr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_conv_done && dr_rd && !flags_o[FB_OVR]) |=> (!flags_o[FB_OVR] && flags_o[FB_EOC]));
    // R5
    rd_clears_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_rd && !ev_conv_done) |=> !flags_o[FB_EOC]);
    // R8
    no_ovr_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_conv_done && !flags_o[FB_EOC] && !flags_o[FB_OVR]) |=> !flags_o[FB_OVR]);
endmodule

// File: tb/sim_adc_flag_ctrl.sv
module sim_adc_flag_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 3;
    localparam int NF = NW + 7;
    localparam int B_EOC = 2;
    localparam int B_OVR = 4;
    localparam int B_CFG = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_ready = 0, ev_smp_end = 0, ev_conv_done = 0, ev_seq_done = 0;
    logic ev_cal_done = 0, ev_cfg_applied = 0;
    logic [NW-1:0] ev_wdg = '0;
    logic reg_wr_en = 0;
    logic [NF-1:0] reg_wdata = '0;
    logic dr_rd = 0, cfg_wr_req = 0;
    logic [NF-1:0] flags_o;
    logic cfg_wr_ok, start_ok;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [NF-1:0] mf = '0;
    logic mpend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_flag_ctrl #(.NUM_WDG(NW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_ready(ev_ready), .ev_smp_end(ev_smp_end), .ev_conv_done(ev_conv_done),
        .ev_seq_done(ev_seq_done), .ev_cal_done(ev_cal_done),
        .ev_cfg_applied(ev_cfg_applied), .ev_wdg(ev_wdg),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .dr_rd(dr_rd),
        .cfg_wr_req(cfg_wr_req), .flags_o(flags_o),
        .cfg_wr_ok(cfg_wr_ok), .start_ok(start_ok)
    );

    // ev uses the flag bit positions; bit 4 (overrun) has no event input
    task automatic apply(input logic [NF-1:0] ev, input logic wr,
                         input logic [NF-1:0] wd, input logic rd, input logic creq);
        logic [NF-1:0] clr;
        logic [NF-1:0] nx;
        ev_ready = ev[0]; ev_smp_end = ev[1]; ev_conv_done = ev[2];
        ev_seq_done = ev[3]; ev_cal_done = ev[5]; ev_cfg_applied = ev[6];
        ev_wdg = ev[NF-1:7];
        reg_wr_en = wr; reg_wdata = wd; dr_rd = rd; cfg_wr_req = creq;
        clr = wr ? wd : '0;
        for (int i = 0; i < NF; i++) nx[i] = ev[i] | (mf[i] & ~clr[i]);
        nx[B_EOC] = ev[B_EOC] | (mf[B_EOC] & ~clr[B_EOC] & ~rd);
        nx[B_OVR] = (ev[B_EOC] & mf[B_EOC] & ~rd) | (mf[B_OVR] & ~clr[B_OVR]);
        if (mpend) mpend = ~ev[B_CFG];
        else if (creq && !mf[B_CFG]) mpend = 1'b1;
        mf = nx;
        @(negedge clk);
        ev_ready = 0; ev_smp_end = 0; ev_conv_done = 0; ev_seq_done = 0;
        ev_cal_done = 0; ev_cfg_applied = 0; ev_wdg = '0;
        reg_wr_en = 0; reg_wdata = '0; dr_rd = 0; cfg_wr_req = 0;
    endtask

    task automatic chk(input string tag);
        logic eok, esok;
        eok = !mpend && !mf[B_CFG];
        esok = !mpend;
        tests++;
        if (flags_o !== mf || cfg_wr_ok !== eok || start_ok !== esok) begin
            fails++;
            $display("FAIL %s: flags=%b cfg_ok=%b start_ok=%b expected flags=%b cfg_ok=%b start_ok=%b",
                     tag, flags_o, cfg_wr_ok, start_ok, mf, eok, esok);
        end
    endtask

    task automatic clear_all();
        apply('0, 1'b1, '1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state");

        // R2 / R3 / R4 / R9 sweep over every event-driven flag
        for (int b = 0; b < NF; b++) begin
            if (b == B_OVR) continue;
            for (int st = 0; st < 2; st++)
                for (int s = 0; s < 2; s++)
                    for (int c = 0; c < 2; c++) begin
                        logic [NF-1:0] one;
                        string tag;
                        one = '0; one[b] = 1'b1;
                        clear_all();
                        if (st == 1) apply(one, 1'b0, '0, 1'b0, 1'b0);
                        chk("R2 event sets flag");
                        apply(s ? one : '0, 1'b1, c ? one : '0, 1'b0, 1'b0);
                        if (s && c) tag = "R4 set beats clear";
                        else if (s && b >= 7) tag = "R9 watchdog flag independent";
                        else if (s) tag = "R2 event sets flag";
                        else tag = "R3 write-one clear / write-zero hold";
                        chk(tag);
                    end
        end

        // R3 partial mask: set all, clear alternate bits
        for (int k = 0; k < NF; k++) begin
            logic [NF-1:0] one;
            one = '0; one[k] = 1'b1;
            if (k != B_OVR) apply(one, 1'b0, '0, 1'b0, 1'b0);
        end
        apply('0, 1'b1, 10'b0101010101, 1'b0, 1'b0);
        chk("R3 masked clear");

        // R5..R8 sweep over conversion-done state, event, read, w1c
        for (int e = 0; e < 2; e++)
            for (int cv = 0; cv < 2; cv++)
                for (int rd = 0; rd < 2; rd++)
                    for (int w = 0; w < 2; w++) begin
                        logic [NF-1:0] eoc;
                        string tag;
                        eoc = '0; eoc[B_EOC] = 1'b1;
                        clear_all();
                        if (e == 1) apply(eoc, 1'b0, '0, 1'b0, 1'b0);
                        apply(cv ? eoc : '0, 1'b1, w ? eoc : '0, rd[0], 1'b0);
                        if (cv && e && !rd) tag = "R6 overrun on unread result";
                        else if (cv && e && rd) tag = "R7 read same cycle, no overrun";
                        else if (cv) tag = "R8 no overrun when flag clear";
                        else tag = "R5 read clears conversion flag";
                        chk(tag);
                    end

        // R6 then clear overrun with write-one (R3)
        begin
            logic [NF-1:0] eoc, ovr;
            eoc = '0; eoc[B_EOC] = 1'b1;
            ovr = '0; ovr[B_OVR] = 1'b1;
            clear_all();
            apply(eoc, 1'b0, '0, 1'b0, 1'b0);
            apply(eoc, 1'b0, '0, 1'b0, 1'b0);
            chk("R6 overrun raised");
            apply('0, 1'b1, ovr, 1'b0, 1'b0);
            chk("R3 overrun cleared by write-one");
        end

        // R10 / R11 configuration handshake
        begin
            logic [NF-1:0] cfg;
            cfg = '0; cfg[B_CFG] = 1'b1;
            clear_all();
            chk("R10 idle gate open");
            apply('0, 1'b0, '0, 1'b0, 1'b1);
            chk("R10 request makes update pending");
            apply('0, 1'b0, '0, 1'b0, 1'b1);
            chk("R10 repeated request ignored");
            apply(cfg, 1'b0, '0, 1'b0, 1'b0);
            chk("R11 apply sets acknowledge, start reopens");
            apply('0, 1'b0, '0, 1'b0, 1'b1);
            chk("R11 request ignored while acknowledge set");
            apply('0, 1'b1, cfg, 1'b0, 1'b0);
            chk("R11 clearing acknowledge reopens writes");
            apply('0, 1'b0, '0, 1'b0, 1'b1);
            chk("R10 new request accepted");
            apply(cfg, 1'b1, cfg, 1'b0, 1'b0);
            chk("R4 apply beats acknowledge clear");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule